// File: doc/BRIEF.md
# Serial Two-S-Box PRESENT-128 Encryption Core

This block encrypts one 64-bit block under a 128-bit key with the PRESENT algorithm. It is built to occupy as little area as possible. Only two 4-bit substitution boxes exist in the whole core. The datapath feeds one byte of the state through them per cycle, so one round takes eight substitution cycles. A ninth cycle applies the bit permutation to the whole state. In that same ninth cycle the key schedule borrows the two boxes to substitute the top byte of the rotated key. The core therefore has no separate key-schedule boxes.

An operation begins with a `start` pulse. The first plaintext byte is presented in the same cycle as `start`. The seven remaining plaintext bytes follow on the next seven cycles, and the eight 16-bit key words arrive after them. After 31 rounds the ciphertext leaves one byte per cycle with a valid strobe. The final round-key addition is applied as each byte is driven out. A one-cycle `done` pulse closes the operation. `busy` covers the whole span from the cycle after `start` to the last output byte.

Top module: `presentSerialCore`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `done` and `outValid` are 0 and `dataOut` is 0.
- R2: `start` is sampled only while `busy` is 0. A `start` asserted while `busy` is 1 has no effect: the running operation's ciphertext and timing are unchanged, and `busy` stays 1 until `done`.
- R3: Load order, counting the edge that samples `start` as load cycle 0. Cycles 0 to 7 take plaintext bytes from `dataIn`, bits 63:56 first and 7:0 last. Cycles 8 to 15 take key words from `keyIn`, bits 127:112 first and 15:0 last. `dataIn` and `keyIn` are ignored at all other times.
- R4: The ciphertext is PRESENT encryption with a 128-bit key, described in the following items.
  - Each of 31 rounds XORs the round key into the state, then applies the S-box, then the permutation. The round key is bits 127:64 of the key register.
  - The S-box maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
  - The permutation moves bit i to bit 16·i mod 63 for i < 63, and bit 63 stays in place.
  - The key update after round r (r = 1..31) has three steps: rotate the key register left by 61, substitute bits 127:120 as two nibbles, then XOR r into bits 66:62.
  - A final round-key XOR follows round 31.
  - An all-zero plaintext with an all-zero key gives 96db702a2e6900af.
- R5: Counting the edge that samples `start` as edge 1, the first ciphertext byte is on `dataOut` with `outValid` = 1 right after edge 295. This is 16 load edges plus 31 rounds of 9 edges each.
- R6: The ciphertext leaves as exactly 8 bytes on 8 consecutive cycles with `outValid` = 1, bits 63:56 first. `dataOut` is 0 whenever `outValid` is 0.
- R7: `busy` is 1 from the cycle after the `start` edge through the last output byte. `done` is 1 for exactly one cycle, the cycle right after the last byte, and `busy` and `outValid` are 0 in that cycle.
- R8: A `start` given in the `done` cycle begins a new operation at once, with the same load order and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when busy is low; carries plaintext byte 0 in the same cycle |
| dataIn | input | 8 | Plaintext byte during load cycles 0 to 7 |
| keyIn | input | 16 | Key word during load cycles 8 to 15 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the last ciphertext byte |
| outValid | output | 1 | dataOut carries a ciphertext byte |
| dataOut | output | 8 | Ciphertext byte, most significant first; zero when not valid |

## Verification
The bench runs the all-zero known-answer vector and the all-ones plaintext and key patterns. It also runs seeded random blocks and keys, all compared against an independent encryption function, so a wrong S-box entry, a wrong permutation index, a key rotation by the wrong amount, or a round counter XORed into the wrong bits gives a wrong ciphertext. The bench pulses `start` while rounds are running. A core that restarted, or that let its load path sample `dataIn` or `keyIn` during rounds, would produce a corrupted block. It also starts a second operation in the `done` cycle, which a core that needed an extra idle cycle would drop. Every operation is timed edge by edge, so a missing round, an off-by-one substitution phase, or a byte-ordering slip on output shows up as a wrong first-valid cycle, a wrong byte count or a wrong `done` position.

// File: rtl/presentPkg.sv
package presentPkg;

  localparam int BYTE_SEL_W = 3;
  localparam int ROUND_W    = 5;

  typedef struct packed {
    logic                  loadData;
    logic                  loadKey;
    logic                  subStep;
    logic                  permStep;
    logic                  outEn;
    logic [BYTE_SEL_W-1:0] byteSel;
    logic [ROUND_W-1:0]    roundNum;
  } ctrlT;

  function automatic logic [3:0] sbox4(input logic [3:0] x);
    logic [3:0] y;
    case (x)
      4'h0: y = 4'hC;  4'h1: y = 4'h5;  4'h2: y = 4'h6;  4'h3: y = 4'hB;
      4'h4: y = 4'h9;  4'h5: y = 4'h0;  4'h6: y = 4'hA;  4'h7: y = 4'hD;
      4'h8: y = 4'h3;  4'h9: y = 4'hE;  4'hA: y = 4'hF;  4'hB: y = 4'h8;
      4'hC: y = 4'h4;  4'hD: y = 4'h7;  4'hE: y = 4'h1;  default: y = 4'h2;
    endcase
    return y;
  endfunction

endpackage

// File: rtl/presentCtrl.sv
module presentCtrl
  import presentPkg::*;
#(
  parameter int ROUNDS     = 31,
  parameter int SUB_STEPS  = 8,
  parameter int DATA_STEPS = 8,
  parameter int KEY_STEPS  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output ctrlT ctrl,
  output logic busy,
  output logic done,
  output logic outValid
);

  localparam int LOAD_STEPS = DATA_STEPS + KEY_STEPS;
  localparam int CNT_W      = $clog2(LOAD_STEPS);
  localparam int PH_W       = $clog2(SUB_STEPS + 1);
  localparam logic [CNT_W-1:0]   LOAD_LAST  = CNT_W'(LOAD_STEPS - 1);
  localparam logic [CNT_W-1:0]   DATA_END   = CNT_W'(DATA_STEPS);
  localparam logic [CNT_W-1:0]   OUT_LAST   = CNT_W'(DATA_STEPS - 1);
  localparam logic [PH_W-1:0]    PERM_PH    = PH_W'(SUB_STEPS);
  localparam logic [ROUND_W-1:0] LAST_ROUND = ROUND_W'(ROUNDS);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ROUND, S_OUT, S_FIN} fsmT;

  fsmT                fsmQ;
  logic [CNT_W-1:0]   cntQ;
  logic [PH_W-1:0]    phaseQ;
  logic [ROUND_W-1:0] roundQ;
  logic               canStart;

  assign canStart = (fsmQ == S_IDLE) || (fsmQ == S_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsmQ   <= S_IDLE;
      cntQ   <= '0;
      phaseQ <= '0;
      roundQ <= '0;
    end else begin
      case (fsmQ)
        S_IDLE, S_FIN: begin
          if (start) begin
            fsmQ <= S_LOAD;
            cntQ <= CNT_W'(1);
          end else begin
            fsmQ <= S_IDLE;
          end
        end
        S_LOAD: begin
          cntQ <= cntQ + CNT_W'(1);
          if (cntQ == LOAD_LAST) begin
            fsmQ   <= S_ROUND;
            phaseQ <= '0;
            roundQ <= ROUND_W'(1);
          end
        end
        S_ROUND: begin
          if (phaseQ == PERM_PH) begin
            phaseQ <= '0;
            roundQ <= roundQ + ROUND_W'(1);
            if (roundQ == LAST_ROUND) begin
              fsmQ <= S_OUT;
              cntQ <= '0;
            end
          end else begin
            phaseQ <= phaseQ + PH_W'(1);
          end
        end
        S_OUT: begin
          cntQ <= cntQ + CNT_W'(1);
          if (cntQ == OUT_LAST) fsmQ <= S_FIN;
        end
        default: fsmQ <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl = '0;
    case (fsmQ)
      S_IDLE, S_FIN: ctrl.loadData = start && canStart;
      S_LOAD: begin
        ctrl.loadData = (cntQ < DATA_END);
        ctrl.loadKey  = (cntQ >= DATA_END);
      end
      S_ROUND: begin
        ctrl.subStep  = (phaseQ != PERM_PH);
        ctrl.permStep = (phaseQ == PERM_PH);
        ctrl.byteSel  = phaseQ[BYTE_SEL_W-1:0];
        ctrl.roundNum = roundQ;
      end
      S_OUT: begin
        ctrl.outEn   = 1'b1;
        ctrl.byteSel = cntQ[BYTE_SEL_W-1:0];
      end
      default: ctrl = '0;
    endcase
  end

  assign busy     = (fsmQ == S_LOAD) || (fsmQ == S_ROUND) || (fsmQ == S_OUT);
  assign done     = (fsmQ == S_FIN);
  assign outValid = (fsmQ == S_OUT);

endmodule

// File: rtl/presentDatapath.sv
module presentDatapath
  import presentPkg::*;
#(
  parameter int STATE_W = 64,
  parameter int KEY_W   = 128,
  parameter int DIN_W   = 8,
  parameter int KIN_W   = 16,
  parameter int N_SBOX  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlT             ctrl,
  input  logic [DIN_W-1:0] dataIn,
  input  logic [KIN_W-1:0] keyIn,
  output logic [DIN_W-1:0] dataOut
);

  localparam int SLICE_W = 4 * N_SBOX;
  localparam int ROT     = 61;
  localparam int CTR_LSB = 62;
  localparam int P_MUL   = STATE_W / 4;

  logic [STATE_W-1:0] stateQ;
  logic [KEY_W-1:0]   keyQ;
  logic [STATE_W-1:0] roundKey;
  logic [STATE_W-1:0] rkShift;
  logic [STATE_W-1:0] outShift;
  logic [KEY_W-1:0]   rotKey;
  logic [KEY_W-1:0]   keyNext;
  logic [STATE_W-1:0] permOut;
  logic [SLICE_W-1:0] sboxIn;
  logic [SLICE_W-1:0] sboxOut;
  logic [5:0]         shAmt;

  assign roundKey = keyQ[KEY_W-1 -: STATE_W];
  assign shAmt    = {ctrl.byteSel, 3'b000};
  assign rkShift  = roundKey << shAmt;
  assign outShift = (stateQ ^ roundKey) << shAmt;
  assign rotKey   = {keyQ[KEY_W-ROT-1:0], keyQ[KEY_W-1:KEY_W-ROT]};

  // Shared boxes: state slice during substitution, rotated key top during permutation
  assign sboxIn = ctrl.permStep ? rotKey[KEY_W-1 -: SLICE_W]
                                : (stateQ[STATE_W-1 -: SLICE_W] ^ rkShift[STATE_W-1 -: SLICE_W]);

  for (genvar g = 0; g < N_SBOX; g++) begin : gSbox
    assign sboxOut[4*g +: 4] = sbox4(sboxIn[4*g +: 4]);
  end

  for (genvar i = 0; i < STATE_W - 1; i++) begin : gPerm
    assign permOut[(i * P_MUL) % (STATE_W - 1)] = stateQ[i];
  end
  assign permOut[STATE_W-1] = stateQ[STATE_W-1];

  always_comb begin
    keyNext = rotKey;
    keyNext[KEY_W-1 -: SLICE_W] = sboxOut;
    keyNext[CTR_LSB +: ROUND_W] = rotKey[CTR_LSB +: ROUND_W] ^ ctrl.roundNum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
      keyQ   <= '0;
    end else begin
      if (ctrl.loadData) stateQ <= {stateQ[STATE_W-DIN_W-1:0], dataIn};
      if (ctrl.loadKey)  keyQ   <= {keyQ[KEY_W-KIN_W-1:0], keyIn};
      if (ctrl.subStep)  stateQ <= {stateQ[STATE_W-SLICE_W-1:0], sboxOut};
      if (ctrl.permStep) begin
        stateQ <= permOut;
        keyQ   <= keyNext;
      end
    end
  end

  assign dataOut = ctrl.outEn ? outShift[STATE_W-1 -: DIN_W] : '0;

endmodule

// File: rtl/presentSerialCore.sv
module presentSerialCore
  import presentPkg::*;
#(
  parameter int STATE_W = 64,
  parameter int KEY_W   = 128,
  parameter int DIN_W   = 8,
  parameter int KIN_W   = 16,
  parameter int ROUNDS  = 31,
  parameter int N_SBOX  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIN_W-1:0] dataIn,
  input  logic [KIN_W-1:0] keyIn,
  output logic             busy,
  output logic             done,
  output logic             outValid,
  output logic [DIN_W-1:0] dataOut
);

  localparam int SUB_STEPS  = STATE_W / (4 * N_SBOX);
  localparam int DATA_STEPS = STATE_W / DIN_W;
  localparam int KEY_STEPS  = KEY_W / KIN_W;

  ctrlT ctrl;

  presentCtrl #(
    .ROUNDS(ROUNDS), .SUB_STEPS(SUB_STEPS),
    .DATA_STEPS(DATA_STEPS), .KEY_STEPS(KEY_STEPS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .ctrl(ctrl),
    .busy(busy), .done(done), .outValid(outValid)
  );

  presentDatapath #(
    .STATE_W(STATE_W), .KEY_W(KEY_W), .DIN_W(DIN_W),
    .KIN_W(KIN_W), .N_SBOX(N_SBOX)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .dataIn(dataIn), .keyIn(keyIn), .dataOut(dataOut)
  );

endmodule

// File: rtl/presentSerialChecker.sv
module presentSerialChecker #(
  parameter int DIN_W     = 8,
  parameter int LAT_FIRST = 295,
  parameter int OUT_BYTES = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             outValid,
  input logic [DIN_W-1:0] dataOut
);

  logic [9:0] latCnt;
  logic [3:0] vCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latCnt <= '0;
      vCnt   <= '0;
    end else begin
      if (start && !busy) latCnt <= 10'd1;
      else if (busy && latCnt != 0) latCnt <= latCnt + 10'd1;
      if (outValid) vCnt <= vCnt + 4'd1;
      else vCnt <= '0;
    end
  end

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busy && !done && !outValid && dataOut == '0));

  // R2
  p_busy_until_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  // R5
  p_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (latCnt == 10'(LAT_FIRST)));

  // R6
  p_eight_bytes_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> (vCnt == 4'(OUT_BYTES)));

  p_zero_idle_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (dataOut == '0));

  p_valid_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);

  // R7
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> (done && !busy));

  // R8
  p_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> busy);

endmodule

bind presentSerialCore presentSerialChecker #(.DIN_W(DIN_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .outValid(outValid), .dataOut(dataOut)
);

// File: tb/presentSerialCore_tb_top.sv
module presentSerialCore_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [15:0] keyIn = '0;
  logic        busy, done, outValid;
  logic [7:0]  dataOut;

  int nChecks = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  presentSerialCore dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn), .keyIn(keyIn),
    .busy(busy), .done(done), .outValid(outValid), .dataOut(dataOut)
  );

  function automatic logic [3:0] refSbox(input logic [3:0] x);
    logic [63:0] tbl;
    tbl = 64'hC56B90AD3EF84712;
    return tbl[60 - 4*x +: 4];
  endfunction

  function automatic logic [63:0] refEncrypt(input logic [63:0] pt, input logic [127:0] key);
    logic [63:0]  s, t;
    logic [127:0] k;
    s = pt;
    k = key;
    for (int r = 1; r <= 31; r++) begin
      s = s ^ k[127:64];
      for (int n = 0; n < 16; n++) s[4*n +: 4] = refSbox(s[4*n +: 4]);
      t = '0;
      for (int b = 0; b < 63; b++) t[(b*16) % 63] = s[b];
      t[63] = s[63];
      s = t;
      k = {k[66:0], k[127:67]};
      k[127:124] = refSbox(k[127:124]);
      k[123:120] = refSbox(k[123:120]);
      k[66:62] = k[66:62] ^ 5'(r);
    end
    return s ^ k[127:64];
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; returns at the negedge where done should be high.
  task automatic doOp(input logic [63:0] pt, input logic [127:0] key, input bit poke, input bit kat);
    logic [63:0]  got, sh, expCt;
    logic [127:0] ksh;
    int firstV, nV;
    bit zeroBad, busyBad;
    got = '0; firstV = -1; nV = 0; zeroBad = 0; busyBad = 0;
    expCt = refEncrypt(pt, key);
    start = 1'b1;
    dataIn = pt[63:56];
    keyIn = 16'hFFFF;
    for (int k = 1; k <= 303; k++) begin
      @(negedge clk);
      if (k < 303 && !busy) busyBad = 1;
      if (outValid) begin
        if (firstV < 0) firstV = k;
        got = {got[55:0], dataOut};
        nV++;
      end else if (dataOut != 8'h00) begin
        zeroBad = 1;
      end
      sh  = pt << (8*k);
      ksh = key << (16*(k-8));
      start  = poke && (k >= 100) && (k <= 104);
      dataIn = (k < 8) ? sh[63:56] : 8'hA5;
      keyIn  = (k >= 8 && k < 16) ? ksh[127:112] : 16'h5A5A;
    end
    start = 1'b0;
    check(got == expCt, "R4 R3 ciphertext", {64'h0, got}, {64'h0, expCt});
    if (kat) check(got == 64'h96db702a2e6900af, "R4 zero known answer", {64'h0, got}, 128'h96db702a2e6900af);
    if (poke) check(got == expCt, "R2 start during rounds ignored", {64'h0, got}, {64'h0, expCt});
    check(firstV == 295, "R5 first byte edge", 128'(firstV), 128'd295);
    check(nV == 8, "R6 byte count", 128'(nV), 128'd8);
    check(!zeroBad, "R6 dataOut zero when not valid", 128'(zeroBad), 128'd0);
    check(!busyBad, "R7 busy held through output", 128'(busyBad), 128'd0);
    check(done && !busy && !outValid, "R7 done pulse after last byte",
          {125'h0, done, busy, outValid}, 128'h4);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", nChecks + 1, nBad);
    $finish;
  end

  initial begin
    logic [63:0]  rp;
    logic [127:0] rk;
    void'($urandom(32'h1C3D5E7F));
    repeat (3) @(negedge clk);
    check(!busy && !done && !outValid && dataOut == 0, "R1 quiet in reset",
          {124'h0, busy, done, outValid, |dataOut}, 128'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !outValid, "R1 idle after reset",
          {125'h0, busy, done, outValid}, 128'h0);
    check(dataOut == 8'h00, "R1 dataOut zero after reset", 128'(dataOut), 128'h0);

    doOp(64'h0, 128'h0, 1'b0, 1'b1);
    @(negedge clk);
    check(!done && !busy, "R7 done lasts one cycle", {126'h0, done, busy}, 128'h0);

    doOp(64'hFFFFFFFFFFFFFFFF, 128'h0, 1'b0, 1'b0);
    @(negedge clk);
    doOp(64'h0, {128{1'b1}}, 1'b0, 1'b0);
    @(negedge clk);
    doOp(64'h0123456789ABCDEF, 128'h00112233445566778899AABBCCDDEEFF, 1'b1, 1'b0);
    // R8: start in the done cycle
    doOp(64'hFEDCBA9876543210, 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F, 1'b0, 1'b0);
    doOp({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 1'b0, 1'b0);
    check(done, "R8 back-to-back op completed", 128'(done), 128'h1);
    @(negedge clk);
    for (int n = 0; n < 5; n++) begin
      rp = {$urandom, $urandom};
      rk = {$urandom, $urandom, $urandom, $urandom};
      doOp(rp, rk, n[0], 1'b0);
      repeat (n + 1) @(negedge clk);
    end
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule